// File: doc/BRIEF.md
# Streaming Matrix Engine Controller

This block is the control sequencer for a small integer multiply array that is fed and drained over streams. One wide inbound stream (512 bits per beat, valid/ready, with a last marker) carries a batch in two sections: first the weight bytes, then the activation bytes. The controller unpacks each beat into byte lanes and steers the bytes into a weight store, kept per array column, and into an activation store. Only after both sections have ended does it feed activation rows, one per handshake, into a systolic array stub that has valid/ready ports. Each row's 32-bit results are packed sixteen to an outbound 512-bit beat, which is sent as soon as it is full or the batch ends.

Software or a wrapper launches a batch by raising `start`. No configuration registers exist. `idle` and a one-cycle `done` pulse report progress. If `start` is still high when a batch finishes, the next batch begins loading at once, without a stop in the idle state.

The controller states are IDLE, LOAD_W, LOAD_A, RUN, DRAIN and DONE, with these transitions: IDLE to LOAD_W on `start`; LOAD_W to LOAD_A on the accepted beat that carries `s_tlast`; LOAD_A to RUN on the accepted beat that carries `s_tlast`; RUN to DRAIN once every activation row has been issued to the array; DRAIN to DONE once every row result has been packed and the final beat has been accepted; DONE to LOAD_W when `start` is high, otherwise DONE to IDLE.

Top module: `matrix_stream_engine`

## Requirements
- R1: While reset is asserted and directly after it is released, `idle`=1, `done`=0, `s_tready`=0 and `m_tvalid`=0.
- R2: `idle` is high only in IDLE. `s_tready` is high only in LOAD_W and LOAD_A. A cycle with `start` high in IDLE moves the block to LOAD_W at the next edge.
- R3: Byte lane b of an inbound beat is `s_tdata[8b+7:8b]`. The valid lanes are the low lanes counted by `s_tkeep`. Bytes are numbered in arrival order across beats, and weight byte number k*N+j is the weight from input k to column j (N=4). Weight bytes past N*N are ignored.
- R4: Weights are complete before any row enters the array: the array is fed only after the activation section's last beat, and never while an inbound beat can be accepted.
- R5: The row count is floor(activation bytes / N), capped at MAX_ROWS (8). Activation bytes past the cap, and the bytes of a trailing partial row, are ignored.
- R6: For activation row r, the result for column j is the signed 32-bit sum over k of a[r][k]*w[k][j], with every operand taken as a signed 8-bit value.
- R7: Result words go out in order r*N+j, with word w of a beat at `m_tdata[32w+31:32w]`. A beat that is not the last of the batch carries 16 words and has all `m_tkeep` bits set.
- R8: The final beat has `m_tlast`=1. In a partial final beat, the unused words are zero and their `m_tkeep` bits are clear. `m_tlast` is 0 on every other beat.
- R9: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values, so no result is lost.
- R10: `done` is high for exactly one cycle after the final beat is accepted. A batch with zero rows reaches DONE without sending any beat.
- R11: If `start` is high in DONE, the block goes straight to LOAD_W and `idle` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a batch (level-sensitive) |
| done | output | 1 | One-cycle pulse when a batch completes |
| idle | output | 1 | High in the idle state only |
| s_tdata | input | 512 | Inbound beat, byte lanes lowest first |
| s_tkeep | input | 64 | Inbound byte-valid mask, contiguous from lane 0 |
| s_tlast | input | 1 | Ends the weight section or the activation section |
| s_tvalid | input | 1 | Inbound beat valid |
| s_tready | output | 1 | Inbound beat accepted when high with valid |
| m_tdata | output | 512 | Outbound beat of 16 result words |
| m_tkeep | output | 64 | Outbound byte enables |
| m_tlast | output | 1 | Final outbound beat of the batch |
| m_tvalid | output | 1 | Outbound beat valid |
| m_tready | input | 1 | Downstream accepts the outbound beat |

## Verification
The bench targets sections split across beats at odd byte counts. A design that restarted its byte numbering on each beat would place bytes in the wrong slots, and the results would come out wrong. The row-count boundaries are covered in turn: an exact single beat, a partial final beat, two full beats, a section with too many bytes that must be capped at eight rows, and a section too short to form a row. A packer that padded badly, dropped a word under back-pressure, or asserted the last marker early shows up in the per-word, byte-enable and last-marker comparisons. Other checks catch a `done` pulse longer than one cycle and a held start that went back through idle.

// File: rtl/mse_pkg.sv
package mse_pkg;

    // Controller sequence: load weights, load activations, compute, flush, report.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD_W = 3'd1,
        ST_LOAD_A = 3'd2,
        ST_RUN    = 3'd3,
        ST_DRAIN  = 3'd4,
        ST_DONE   = 3'd5
    } mse_state_e;

endpackage

// File: rtl/mse_ingest.sv
// Unpacks wide inbound beats into the weight store and the activation store.
module mse_ingest #(
    parameter int IN_W     = 512,
    parameter int N        = 4,
    parameter int MAX_ROWS = 8,
    parameter int OFF_W    = 16,
    parameter int ROW_W    = $clog2(MAX_ROWS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    beat_fire,
    input  logic                    act_phase,
    input  logic [IN_W-1:0]         beat_data,
    input  logic [IN_W/8-1:0]       beat_keep,
    output logic [N*N*8-1:0]        w_flat,
    output logic [MAX_ROWS*N*8-1:0] a_flat,
    output logic [ROW_W-1:0]        a_rows
);
    localparam int LANES   = IN_W / 8;
    localparam int W_BYTES = N * N;
    localparam int A_BYTES = MAX_ROWS * N;
    localparam int KC_W    = $clog2(LANES + 1);

    logic [KC_W-1:0]  beat_bytes;
    logic [OFF_W-1:0] w_off;
    logic [OFF_W-1:0] a_off;
    logic [OFF_W-1:0] full_rows;

    assign beat_bytes = KC_W'($countones(beat_keep));

    function automatic logic [7:0] lane_byte(input logic [IN_W-1:0] d,
                                             input logic [OFF_W-1:0] lane);
        logic [IN_W-1:0] s;
        s = d >> {lane, 3'b000};
        return s[7:0];
    endfunction

    // Running byte offsets per section; they stop growing once the store is full.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_off <= '0;
            a_off <= '0;
        end else if (clr) begin
            w_off <= '0;
            a_off <= '0;
        end else if (beat_fire) begin
            if (!act_phase && (w_off < OFF_W'(W_BYTES)))
                w_off <= w_off + OFF_W'(beat_bytes);
            if (act_phase && (a_off < OFF_W'(A_BYTES)))
                a_off <= a_off + OFF_W'(beat_bytes);
        end
    end

    // Weight store: byte k*N+j belongs to column j.
    for (genvar i = 0; i < W_BYTES; i++) begin : g_wbyte
        logic [7:0] wq;
        logic       hit;
        assign hit = beat_fire && !act_phase && (OFF_W'(i) >= w_off) &&
                     ((OFF_W'(i) - w_off) < OFF_W'(beat_bytes));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     wq <= '0;
            else if (clr)   wq <= '0;
            else if (hit)   wq <= lane_byte(beat_data, OFF_W'(i) - w_off);
        end
        assign w_flat[i*8 +: 8] = wq;
    end

    // Activation store: byte r*N+k is input k of row r.
    for (genvar i = 0; i < A_BYTES; i++) begin : g_abyte
        logic [7:0] aq;
        logic       hit;
        assign hit = beat_fire && act_phase && (OFF_W'(i) >= a_off) &&
                     ((OFF_W'(i) - a_off) < OFF_W'(beat_bytes));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     aq <= '0;
            else if (clr)   aq <= '0;
            else if (hit)   aq <= lane_byte(beat_data, OFF_W'(i) - a_off);
        end
        assign a_flat[i*8 +: 8] = aq;
    end

    assign full_rows = a_off / OFF_W'(N);
    assign a_rows    = (full_rows > OFF_W'(MAX_ROWS)) ? ROW_W'(MAX_ROWS) : ROW_W'(full_rows);

    // Overflow bytes leave the stores untouched.
    assert_w_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && !act_phase && !clr && (w_off >= OFF_W'(W_BYTES))) |=> $stable(w_flat));
    assert_a_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && act_phase && !clr && (a_off >= OFF_W'(A_BYTES))) |=> $stable(a_flat));

endmodule

// File: rtl/mse_array_stub.sv
// Behavioural stand-in for the systolic array: one row in, N accumulator words out.
module mse_array_stub #(
    parameter int N     = 4,
    parameter int ACC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N*N*8-1:0]   w_flat,
    input  logic [N*8-1:0]     row_in,
    input  logic               row_valid,
    output logic               row_ready,
    output logic [N*ACC_W-1:0] res_out,
    output logic               res_valid,
    input  logic               res_ready
);
    logic [N*ACC_W-1:0] sum_c;

    always_comb begin
        sum_c = '0;
        for (int j = 0; j < N; j++) begin
            logic signed [ACC_W-1:0] acc;
            acc = '0;
            for (int k = 0; k < N; k++) begin
                logic signed [ACC_W-1:0] av;
                logic signed [ACC_W-1:0] wv;
                av  = ACC_W'($signed(row_in[k*8 +: 8]));
                wv  = ACC_W'($signed(w_flat[(k*N+j)*8 +: 8]));
                acc = acc + av * wv;
            end
            sum_c[j*ACC_W +: ACC_W] = acc;
        end
    end

    assign row_ready = !res_valid || res_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_out   <= '0;
        end else if (row_valid && row_ready) begin
            res_valid <= 1'b1;
            res_out   <= sum_c;
        end else if (res_ready) begin
            res_valid <= 1'b0;
        end
    end

    assert_res_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_out)));

endmodule

// File: rtl/mse_packer.sv
// Packs N-word result rows into wide outbound beats with byte enables.
module mse_packer #(
    parameter int N     = 4,
    parameter int ACC_W = 32,
    parameter int OUT_W = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N*ACC_W-1:0] res_in,
    input  logic               res_valid,
    input  logic               res_last,
    output logic               res_ready,
    output logic [OUT_W-1:0]   m_data,
    output logic [OUT_W/8-1:0] m_keep,
    output logic               m_last,
    output logic               m_valid,
    input  logic               m_ready
);
    localparam int WPB = OUT_W / ACC_W;
    localparam int CW  = $clog2(WPB + 1);
    localparam int WB  = ACC_W / 8;

    logic [CW-1:0] cnt;
    logic          accept;
    logic          flush;

    assign res_ready = !m_valid;
    assign accept    = res_valid && res_ready;
    assign flush     = m_valid && m_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            m_valid <= 1'b0;
            m_last  <= 1'b0;
        end else if (flush) begin
            cnt     <= '0;
            m_valid <= 1'b0;
            m_last  <= 1'b0;
        end else if (accept) begin
            cnt <= cnt + CW'(N);
            if ((cnt + CW'(N) == CW'(WPB)) || res_last) begin
                m_valid <= 1'b1;
                m_last  <= res_last;
            end
        end
    end

    for (genvar w = 0; w < WPB; w++) begin : g_word
        logic [ACC_W-1:0]   word_q;
        logic               in_win;
        logic [CW-1:0]      slot;
        logic [N*ACC_W-1:0] sh;
        assign slot   = CW'(w) - cnt;
        assign in_win = (CW'(w) >= cnt) && (CW'(w) < cnt + CW'(N));
        assign sh     = res_in >> (32'(slot) * ACC_W);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 word_q <= '0;
            else if (flush)             word_q <= '0;
            else if (accept && in_win)  word_q <= sh[ACC_W-1:0];
        end
        assign m_data[w*ACC_W +: ACC_W] = word_q;
        assign m_keep[w*WB +: WB]       = {WB{CW'(w) < cnt}};
    end

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
    assert_full_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_last) |-> (&m_keep));
    assert_last_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_last) |-> m_keep[0]);

endmodule

// File: rtl/matrix_stream_engine.sv
// Sequencer: weight load, activation load, array run, result drain.
module matrix_stream_engine
    import mse_pkg::*;
#(
    parameter int IN_W     = 512,
    parameter int OUT_W    = 512,
    parameter int N        = 4,
    parameter int MAX_ROWS = 8,
    parameter int ACC_W    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               done,
    output logic               idle,
    input  logic [IN_W-1:0]    s_tdata,
    input  logic [IN_W/8-1:0]  s_tkeep,
    input  logic               s_tlast,
    input  logic               s_tvalid,
    output logic               s_tready,
    output logic [OUT_W-1:0]   m_tdata,
    output logic [OUT_W/8-1:0] m_tkeep,
    output logic               m_tlast,
    output logic               m_tvalid,
    input  logic               m_tready
);
    localparam int ROW_W = $clog2(MAX_ROWS + 1);
    localparam int OFF_W = 16;

    mse_state_e state_q, state_d;

    logic [ROW_W-1:0]          issued_q;
    logic [ROW_W-1:0]          got_q;
    logic [ROW_W-1:0]          a_rows;
    logic [N*N*8-1:0]          w_flat;
    logic [MAX_ROWS*N*8-1:0]   a_flat;
    logic [MAX_ROWS*N*8-1:0]   a_sh;
    logic                      beat_fire;
    logic                      restart;
    logic                      arr_row_valid;
    logic                      arr_row_ready;
    logic [N*ACC_W-1:0]        arr_res;
    logic                      arr_res_valid;
    logic                      arr_res_ready;
    logic                      res_last;

    assign beat_fire     = s_tvalid && s_tready;
    assign restart       = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign arr_row_valid = (state_q == ST_RUN) && (issued_q < a_rows);
    assign a_sh          = a_flat >> (32'(issued_q) * (N * 8));
    assign res_last      = (got_q == a_rows - ROW_W'(1));

    mse_ingest #(
        .IN_W(IN_W), .N(N), .MAX_ROWS(MAX_ROWS), .OFF_W(OFF_W), .ROW_W(ROW_W)
    ) u_ingest (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (restart),
        .beat_fire (beat_fire),
        .act_phase (state_q == ST_LOAD_A),
        .beat_data (s_tdata),
        .beat_keep (s_tkeep),
        .w_flat    (w_flat),
        .a_flat    (a_flat),
        .a_rows    (a_rows)
    );

    mse_array_stub #(.N(N), .ACC_W(ACC_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .w_flat    (w_flat),
        .row_in    (a_sh[N*8-1:0]),
        .row_valid (arr_row_valid),
        .row_ready (arr_row_ready),
        .res_out   (arr_res),
        .res_valid (arr_res_valid),
        .res_ready (arr_res_ready)
    );

    mse_packer #(.N(N), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_in    (arr_res),
        .res_valid (arr_res_valid),
        .res_last  (res_last),
        .res_ready (arr_res_ready),
        .m_data    (m_tdata),
        .m_keep    (m_tkeep),
        .m_last    (m_tlast),
        .m_valid   (m_tvalid),
        .m_ready   (m_tready)
    );

    // State register and batch counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            issued_q <= '0;
            got_q    <= '0;
        end else begin
            state_q <= state_d;
            if (restart) begin
                issued_q <= '0;
                got_q    <= '0;
            end else begin
                if (arr_row_valid && arr_row_ready) issued_q <= issued_q + ROW_W'(1);
                if (arr_res_valid && arr_res_ready) got_q    <= got_q + ROW_W'(1);
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)                        state_d = ST_LOAD_W;
            ST_LOAD_W: if (beat_fire && s_tlast)         state_d = ST_LOAD_A;
            ST_LOAD_A: if (beat_fire && s_tlast)         state_d = ST_RUN;
            ST_RUN:    if (issued_q == a_rows)           state_d = ST_DRAIN;
            ST_DRAIN:  if ((got_q == a_rows) && !m_tvalid) state_d = ST_DONE;
            ST_DONE:   state_d = start ? ST_LOAD_W : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the current state.
    always_comb begin
        idle     = 1'b0;
        done     = 1'b0;
        s_tready = 1'b0;
        unique case (state_q)
            ST_IDLE:   idle     = 1'b1;
            ST_LOAD_W: s_tready = 1'b1;
            ST_LOAD_A: s_tready = 1'b1;
            ST_RUN:    ;
            ST_DRAIN:  ;
            ST_DONE:   done     = 1'b1;
            default:   ;
        endcase
    end

    assert_start_leaves_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start) |=> (s_tready && !idle));
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!s_tready && !m_tvalid));
    assert_feed_after_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_row_valid |-> !s_tready);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_flushed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !m_tvalid);
    assert_rerun_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!idle && s_tready));

endmodule

// File: tb/tb_matrix_stream_engine.sv
`timescale 1ns/1ps
module tb_matrix_stream_engine;
    localparam int N     = 4;
    localparam int MAXR  = 8;
    localparam int IN_W  = 512;
    localparam int OUT_W = 512;
    localparam int WPB   = 16;
    localparam int NV    = 6;
    // abytes, wextra, wchunk, achunk, throttle, seed
    localparam int VEC [NV][6] = '{
        '{ 4, 0, 16,  4, 0, 1},   // one row, partial final beat (R8)
        '{16, 0, 16, 16, 0, 2},   // exactly one full beat (R7)
        '{22, 4,  7,  5, 1, 3},   // trailing partial row, extra weights (R3, R5)
        '{32, 0,  3, 32, 2, 4},   // two full beats, throttled (R9)
        '{44, 0, 64, 11, 1, 5},   // capped at eight rows (R5)
        '{20, 8,  5,  3, 2, 6}    // many small beats (R3)
    };

    logic clk = 1'b0;
    logic rst_n;
    logic start;
    logic done, idle;
    logic [IN_W-1:0]    s_tdata;
    logic [IN_W/8-1:0]  s_tkeep;
    logic s_tlast, s_tvalid, s_tready;
    logic [OUT_W-1:0]   m_tdata;
    logic [OUT_W/8-1:0] m_tkeep;
    logic m_tlast, m_tvalid, m_tready;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    matrix_stream_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .idle(idle),
        .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    function automatic logic [7:0] wbyte(input int seed, input int i);
        return 8'((seed * 29 + i * 47 + 3) & 255);
    endfunction

    function automatic logic [7:0] abyte(input int seed, input int i);
        return 8'((seed * 71 + i * 19 + 11) & 255);
    endfunction

    // R6 reference: signed 8-bit operands, weight byte k*N+j (R3).
    function automatic logic [31:0] expect_word(input int seed, input int r, input int j);
        int s;
        s = 0;
        for (int k = 0; k < N; k++)
            s += int'($signed(abyte(seed, r * N + k))) * int'($signed(wbyte(seed, k * N + j)));
        return 32'(s);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R3: bytes numbered in arrival order, low lanes valid per s_tkeep.
    task automatic send_section(input int nbytes, input int chunk, input int seed, input bit is_w);
        int idx;
        bit fin;
        idx = 0;
        fin = 1'b0;
        while (!fin) begin
            int n;
            n = nbytes - idx;
            if (n > chunk) n = chunk;
            @(negedge clk);
            s_tdata = '0;
            s_tkeep = '0;
            for (int b = 0; b < n; b++) begin
                s_tdata[b*8 +: 8] = is_w ? wbyte(seed, idx + b) : abyte(seed, idx + b);
                s_tkeep[b] = 1'b1;
            end
            s_tlast  = (idx + n >= nbytes);
            s_tvalid = 1'b1;
            while (!s_tready) @(negedge clk);
            @(posedge clk);
            idx += n;
            fin = (idx >= nbytes);
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic run_job(input int abytes, input int wextra, input int wchunk,
                           input int achunk, input int thr, input int seed,
                           input bit hold, input bit skip);
        int rows, total, nbeats, beat, cyc, guard, wt;
        bit got_last, pend, seen, spurious;
        logic [OUT_W-1:0] pdata;
        rows = abytes / N;
        if (rows > MAXR) rows = MAXR;
        total  = rows * N;
        nbeats = (total + WPB - 1) / WPB;
        if (!skip) begin
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            chk(s_tready && !idle, "R2", "start enters weight load", {s_tready, idle}, 2'b10);
            if (!hold) start = 1'b0;
        end else begin
            start = hold;
        end
        send_section(N * N + wextra, wchunk, seed, 1'b1);
        chk(s_tready && !m_tvalid, "R4", "activation load follows weights", {s_tready, m_tvalid}, 2'b10);
        send_section(abytes, achunk, seed, 1'b0);

        beat = 0; cyc = 0; guard = 0; got_last = 1'b0; pend = 1'b0; pdata = '0;
        while (!got_last && guard < 2000 && rows > 0) begin
            @(negedge clk);
            guard++;
            cyc++;
            if (pend)
                chk(m_tvalid && (m_tdata == pdata), "R9", "beat held under stall",
                    m_tdata[63:0], pdata[63:0]);
            m_tready = (thr == 0) ? 1'b1 : ((thr == 1) ? (cyc % 2 == 0) : (cyc % 3 == 0));
            pend  = m_tvalid && !m_tready;
            pdata = m_tdata;
            if (m_tvalid && m_tready) begin
                logic [OUT_W/8-1:0] ekeep;
                ekeep = '0;
                for (int w = 0; w < WPB; w++) begin
                    int gi;
                    logic [31:0] ew;
                    gi = beat * WPB + w;
                    ew = (gi < total) ? expect_word(seed, gi / N, gi % N) : 32'h0;
                    if (gi < total) ekeep[w*4 +: 4] = 4'hF;
                    chk(m_tdata[w*32 +: 32] == ew, (gi < total) ? "R6" : "R8",
                        "result word", m_tdata[w*32 +: 32], ew);
                end
                chk(m_tkeep == ekeep, "R7", "byte enables", m_tkeep, ekeep);
                chk(m_tlast == (beat == nbeats - 1), "R8", "last marker",
                    m_tlast, (beat == nbeats - 1));
                beat++;
                if (m_tlast) got_last = 1'b1;
            end
        end
        if (rows > 0)
            chk(got_last && beat == nbeats, "R7", "beat count", beat, nbeats);

        wt = 0; seen = 1'b0; spurious = 1'b0;
        while (!seen && wt < 40) begin
            @(negedge clk);
            wt++;
            if (m_tvalid && rows == 0) spurious = 1'b1;
            if (done) seen = 1'b1;
        end
        m_tready = 1'b0;
        chk(seen, "R10", "done pulse seen", seen, 1);
        if (rows == 0) chk(!spurious, "R10", "empty batch sends nothing", spurious, 0);
        @(negedge clk);
        chk(!done, "R10", "done lasts one cycle", done, 0);
        if (hold) chk(!idle && s_tready, "R11", "held start reloads", {idle, s_tready}, 2'b01);
        else      chk(idle && !s_tready, "R2", "return to idle", {idle, s_tready}, 2'b10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; s_tdata = '0; s_tkeep = '0;
        s_tlast = 1'b0; s_tvalid = 1'b0; m_tready = 1'b0;
        repeat (3) @(negedge clk);
        chk(idle && !done && !s_tready && !m_tvalid, "R1", "in reset",
            {idle, done, s_tready, m_tvalid}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(idle && !done && !s_tready && !m_tvalid, "R1", "after reset",
            {idle, done, s_tready, m_tvalid}, 4'b1000);

        // Table walk (R3, R5, R6, R7, R8, R9).
        for (int v = 0; v < NV; v++)
            run_job(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], 1'b0, 1'b0);

        // R5/R10: too few activation bytes for one row.
        run_job(2, 0, 16, 2, 0, 7, 1'b0, 1'b0);
        // R11: start held through DONE, then a batch with no new start pulse.
        run_job(12, 0, 16, 12, 1, 8, 1'b1, 1'b0);
        run_job(16, 0, 16, 16, 0, 9, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule